// File: doc/BRIEF.md
# ADC Track-and-Convert Sequencer

This block decides when a successive-approximation converter follows its analog input and when it freezes that input and converts it. A start request can come from one of four places: a software write pulse, an overflow from either of two timers, or the rising edge of an external convert-start pin. When the sequencer accepts a start, it steps through an optional tracking window and then a conversion phase. Both phases are counted in SAR clock ticks, and those ticks come from a programmable divider on the system clock. The SAR core is treated as a fixed number of SAR clocks. At completion the sequencer captures the core's output word into a result register and sets a sticky completion flag, which software polls and clears.

There are two tracking behaviours. In continuous mode the hold enable stays asserted except while a conversion runs. In low-power mode the input is tracked only for a short window before each conversion. That window is either three SAR clocks after the start or, when the pin is the trigger source, the time the pin is low. A standby input removes tracking completely. A start request that arrives while the sequencer is busy is dropped.

Top module: `adc_track_seq`

## Requirements
- R1: `trig_sel` selects the trigger source: 0 = `sw_start`, 1 = timer A overflow, 2 = timer B overflow, 3 = rising edge of `cnv_pin`. Activity on any source that is not selected starts nothing.
- R2: For a timer source, `tmr_x_wide`=0 makes the low-byte overflow the trigger and `tmr_x_wide`=1 makes the high-byte overflow the trigger. The other overflow of that timer is ignored.
- R3: With `lp_mode`=0 and `sleep`=0, `track_en` is 1 whenever no conversion is in progress and 0 on every cycle of a conversion.
- R4: With `lp_mode`=1 and a non-pin source, `track_en` is 1 for exactly 3 SAR clocks after the accepting edge, and then conversion follows. `done_flag` rises (3+CONV_CLKS)·(`sar_div`+1) clock edges after the accepting edge.
- R5: With `lp_mode`=1 and the pin source, `track_en` is 1 in idle only while the synchronised pin is low. Conversion starts on the synchronised rising edge, behind two flip-flops of synchronisation. `done_flag` rises 2+CONV_CLKS·(`sar_div`+1) edges after the first edge that sees the pin high.
- R6: While `sleep` is 1, `track_en` is 0 in every state.
- R7: A SAR clock tick occurs every `sar_div`+1 system clocks, and the divider restarts on the accepting edge. A conversion lasts CONV_CLKS ticks. In continuous mode `done_flag` rises CONV_CLKS·(`sar_div`+1) edges after the accepting edge, and on that same edge `result` takes `sar_data`.
- R8: A trigger that arrives while `busy` is 1 is ignored and is not queued. The conversion latency does not change, and no further conversion follows.
- R9: `done_flag` stays 1 until `flag_clr` is applied. If `flag_clr` and a completion fall on the same edge, the flag ends up 1.
- R10: After reset, `busy`, `done_flag`, `conv_strobe` and `result` are 0.
- R11: `conv_strobe` is high for exactly one cycle per conversion, on the first cycle of the conversion phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sar_div | input | DIV_W | SAR clock divider; a tick occurs every sar_div+1 clocks |
| trig_sel | input | 2 | Trigger source select |
| lp_mode | input | 1 | 1 = low-power track-and-hold, 0 = continuous tracking |
| sleep | input | 1 | Standby; forces tracking off |
| sw_start | input | 1 | Software start pulse |
| tmr_a_lo_ovf | input | 1 | Timer A low-byte overflow pulse |
| tmr_a_hi_ovf | input | 1 | Timer A high-byte overflow pulse |
| tmr_a_wide | input | 1 | Timer A is in 16-bit mode |
| tmr_b_lo_ovf | input | 1 | Timer B low-byte overflow pulse |
| tmr_b_hi_ovf | input | 1 | Timer B high-byte overflow pulse |
| tmr_b_wide | input | 1 | Timer B is in 16-bit mode |
| cnv_pin | input | 1 | Asynchronous external convert-start pin |
| sar_data | input | RES_W | Output word of the SAR core |
| flag_clr | input | 1 | Clears the completion flag |
| track_en | output | 1 | Track (1) / hold (0) control to the front end |
| conv_strobe | output | 1 | One-cycle start-of-conversion strobe |
| result | output | RES_W | Captured conversion result |
| done_flag | output | 1 | Sticky completion flag |
| busy | output | 1 | Tracking window or conversion under way |

## Verification
Each result is timed from the edge that accepts the trigger, because the divider restarts on that edge. `done_flag` and `result` are due after CONV_CLKS·(`sar_div`+1) edges in continuous mode and after (3+CONV_CLKS)·(`sar_div`+1) edges in low-power mode. The pin source adds two more edges for synchronisation. The bench counts edges from the trigger at every falling edge and compares the count at which the flag first appears with the expected figure. At each of those falling edges it also tallies the cycles in which `track_en` and `conv_strobe` are high, and checks the tallies against the tracking-window and single-strobe rules. Dropped or unselected triggers are checked by watching `busy` and `done_flag` for a window longer than a conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SRC_SOFT  = 2'd0,
        SRC_TMR_A = 2'd1,
        SRC_TMR_B = 2'd2,
        SRC_PIN   = 2'd3
    } trig_src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRACK = 2'd1,
        ST_CONV  = 2'd2
    } seq_state_e;

    // fixed pre-conversion window of the low-power mode, in SAR ticks
    localparam int unsigned LP_TRACK_CLKS = 3;

    typedef struct packed {
        logic lo_ovf;
        logic hi_ovf;
        logic wide;
    } tmr_ovf_t;

    // a timer in 16-bit mode starts on its upper-byte overflow
    function automatic logic tmr_pick(input tmr_ovf_t t);
        return t.wide ? t.hi_ovf : t.lo_ovf;
    endfunction

endpackage

// File: rtl/adc_sar_tick.sv
module adc_sar_tick #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst || restart || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    assert_tick_wraps_R7: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));

endmodule

// File: rtl/adc_pin_sync.sv
module adc_pin_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic rise
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign level = s2;
    assign rise  = s2 & ~s3;

    assert_rise_single_R5: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
(
    input  trig_src_e src,
    input  logic      sw_start,
    input  tmr_ovf_t  tmr_a,
    input  tmr_ovf_t  tmr_b,
    input  logic      pin_rise,
    output logic      trig
);
    always_comb begin
        unique case (src)
            SRC_SOFT:  trig = sw_start;
            SRC_TMR_A: trig = tmr_pick(tmr_a);
            SRC_TMR_B: trig = tmr_pick(tmr_b);
            SRC_PIN:   trig = pin_rise;
            default:   trig = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int unsigned RES_W     = 10,
    parameter int unsigned CONV_CLKS = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             tick,
    input  logic             lp_mode,
    input  logic             pin_src,
    input  logic             pin_level,
    input  logic             sleep,
    input  logic [RES_W-1:0] sar_data,
    input  logic             flag_clr,
    output logic             accept,
    output logic             track_en,
    output logic             conv_strobe,
    output logic [RES_W-1:0] result,
    output logic             done_flag,
    output logic             busy
);
    localparam int unsigned CNT_W = (CONV_CLKS > 4) ? $clog2(CONV_CLKS) : 2;
    localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_CLKS - 1);
    localparam logic [CNT_W-1:0] TRACK_LAST = CNT_W'(LP_TRACK_CLKS - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             to_track, track_done, complete, trk_raw;

    assign accept     = (state == ST_IDLE) && trig;
    assign to_track   = lp_mode && !pin_src;
    assign track_done = (state == ST_TRACK) && tick && (cnt == TRACK_LAST);
    assign complete   = (state == ST_CONV) && tick && (cnt == CONV_LAST);
    assign busy       = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            conv_strobe <= 1'b0;
        end else begin
            conv_strobe <= 1'b0;
            unique case (state)
                ST_IDLE: if (accept) begin
                    cnt <= '0;
                    if (to_track) begin
                        state <= ST_TRACK;
                    end else begin
                        state       <= ST_CONV;
                        conv_strobe <= 1'b1;
                    end
                end
                ST_TRACK: if (tick) begin
                    if (track_done) begin
                        state       <= ST_CONV;
                        cnt         <= '0;
                        conv_strobe <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CONV: if (tick) begin
                    if (complete) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            done_flag <= 1'b0;
        end else begin
            if (complete) result <= sar_data;
            if (complete)      done_flag <= 1'b1;
            else if (flag_clr) done_flag <= 1'b0;
        end
    end

    always_comb begin
        if (!lp_mode)     trk_raw = (state != ST_CONV);
        else if (pin_src) trk_raw = (state == ST_IDLE) && !pin_level;
        else              trk_raw = (state == ST_TRACK);
    end
    assign track_en = trk_raw && !sleep;

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (done_flag && !flag_clr) |=> done_flag);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        complete |=> done_flag);
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !complete |=> $stable(result));
    assert_hold_in_conv_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV) |-> !track_en);
    assert_busy_drops_trig_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && trig && !track_done && !complete) |=> busy);
    assert_strobe_single_R11: assert property (@(posedge clk) disable iff (rst)
        conv_strobe |=> !conv_strobe);
    assert_track_window_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TRACK) |-> (cnt < CNT_W'(LP_TRACK_CLKS)));

endmodule

// File: rtl/adc_track_seq.sv
module adc_track_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned RES_W     = 10,
    parameter int unsigned CONV_CLKS = 12,
    parameter int unsigned DIV_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] sar_div,
    input  logic [1:0]       trig_sel,
    input  logic             lp_mode,
    input  logic             sleep,
    input  logic             sw_start,
    input  logic             tmr_a_lo_ovf,
    input  logic             tmr_a_hi_ovf,
    input  logic             tmr_a_wide,
    input  logic             tmr_b_lo_ovf,
    input  logic             tmr_b_hi_ovf,
    input  logic             tmr_b_wide,
    input  logic             cnv_pin,
    input  logic [RES_W-1:0] sar_data,
    input  logic             flag_clr,
    output logic             track_en,
    output logic             conv_strobe,
    output logic [RES_W-1:0] result,
    output logic             done_flag,
    output logic             busy
);
    trig_src_e src;
    tmr_ovf_t  ta, tb;
    logic      pin_level, pin_rise, trig, tick, accept;

    assign src = trig_src_e'(trig_sel);
    assign ta  = '{lo_ovf: tmr_a_lo_ovf, hi_ovf: tmr_a_hi_ovf, wide: tmr_a_wide};
    assign tb  = '{lo_ovf: tmr_b_lo_ovf, hi_ovf: tmr_b_hi_ovf, wide: tmr_b_wide};

    adc_pin_sync u_sync (
        .clk(clk), .rst(rst), .pin(cnv_pin), .level(pin_level), .rise(pin_rise)
    );

    adc_trig_sel u_sel (
        .src(src), .sw_start(sw_start), .tmr_a(ta), .tmr_b(tb),
        .pin_rise(pin_rise), .trig(trig)
    );

    adc_sar_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .div(sar_div), .restart(accept), .tick(tick)
    );

    adc_seq_fsm #(.RES_W(RES_W), .CONV_CLKS(CONV_CLKS)) u_fsm (
        .clk(clk), .rst(rst), .trig(trig), .tick(tick), .lp_mode(lp_mode),
        .pin_src(src == SRC_PIN), .pin_level(pin_level), .sleep(sleep),
        .sar_data(sar_data), .flag_clr(flag_clr), .accept(accept),
        .track_en(track_en), .conv_strobe(conv_strobe), .result(result),
        .done_flag(done_flag), .busy(busy)
    );

endmodule

// File: tb/adc_track_seq_tb.sv
`timescale 1ns/1ps
module adc_track_seq_tb_top;
    localparam int RES_W = 10;
    localparam int NCONV = 12;

    logic clk = 1'b0, rst = 1'b1;
    logic [7:0] sar_div = '0;
    logic [1:0] trig_sel = '0;
    logic lp_mode = 0, sleep = 0, sw_start = 0;
    logic tmr_a_lo_ovf = 0, tmr_a_hi_ovf = 0, tmr_a_wide = 0;
    logic tmr_b_lo_ovf = 0, tmr_b_hi_ovf = 0, tmr_b_wide = 0;
    logic cnv_pin = 0, flag_clr = 0;
    logic [RES_W-1:0] sar_data = '0;
    logic track_en, conv_strobe, done_flag, busy;
    logic [RES_W-1:0] result;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;

    adc_track_seq #(.RES_W(RES_W), .CONV_CLKS(NCONV), .DIV_W(8)) dut_i (
        .clk(clk), .rst(rst), .sar_div(sar_div), .trig_sel(trig_sel),
        .lp_mode(lp_mode), .sleep(sleep), .sw_start(sw_start),
        .tmr_a_lo_ovf(tmr_a_lo_ovf), .tmr_a_hi_ovf(tmr_a_hi_ovf), .tmr_a_wide(tmr_a_wide),
        .tmr_b_lo_ovf(tmr_b_lo_ovf), .tmr_b_hi_ovf(tmr_b_hi_ovf), .tmr_b_wide(tmr_b_wide),
        .cnv_pin(cnv_pin), .sar_data(sar_data), .flag_clr(flag_clr),
        .track_en(track_en), .conv_strobe(conv_strobe), .result(result),
        .done_flag(done_flag), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    function automatic int exp_lat(input int d, input bit lp, input bit pin);
        if (pin)     return 2 + NCONV * (d + 1);
        else if (lp) return (3 + NCONV) * (d + 1);
        else         return NCONV * (d + 1);
    endfunction

    function automatic int exp_trk(input int d, input bit lp, input bit pin);
        if (pin) return lp ? 1 : 2;
        return lp ? 3 * (d + 1) : 0;
    endfunction

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
    endtask

    task automatic fire(input logic [1:0] sel, input logic wide, input bit val);
        case (sel)
            2'd0: sw_start = val;
            2'd1: if (wide) tmr_a_hi_ovf = val; else tmr_a_lo_ovf = val;
            2'd2: if (wide) tmr_b_hi_ovf = val; else tmr_b_lo_ovf = val;
            default: cnv_pin = val;
        endcase
    endtask

    // one conversion; late_trig pulses sw_start mid-run (R8)
    task automatic do_conv(input logic [1:0] sel, input bit lp, input int d,
                           input bit wide, input bit late_trig, input string req);
        int lat, trk, stb;
        logic [RES_W-1:0] val;
        bit pin;
        pin = (sel == 2'd3);
        val = RES_W'($urandom);
        clear_flag();
        trig_sel = sel; lp_mode = lp; sar_div = 8'(d);
        tmr_a_wide = wide; tmr_b_wide = wide; sar_data = val;
        repeat (3) @(negedge clk);
        fire(sel, wide, 1'b1);
        @(posedge clk);
        @(negedge clk);
        if (!pin) fire(sel, wide, 1'b0);
        lat = 0; trk = 0; stb = 0;
        while (!done_flag && lat < 3000) begin
            if (track_en) trk++;
            if (conv_strobe) stb++;
            sw_start = (late_trig && lat == 2);
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        sw_start = 0;
        chk(lat == exp_lat(d, lp, pin), {req, " latency"}, lat, exp_lat(d, lp, pin));
        chk(result == val, "R7 result capture", int'(result), int'(val));
        chk(stb == 1, "R11 strobe count", stb, 1);
        chk(trk == exp_trk(d, lp, pin), {req, " track window"}, trk, exp_trk(d, lp, pin));
        cnv_pin = 0;
        repeat (4) @(negedge clk);
        chk(done_flag == 1'b1, "R9 flag sticky", int'(done_flag), 1);
    endtask

    // apply a pulse on a non-trigger input; nothing may start
    task automatic no_start(input string req);
        int seen;
        seen = 0;
        @(posedge clk);
        @(negedge clk);
        sw_start = 0; tmr_a_lo_ovf = 0; tmr_a_hi_ovf = 0;
        tmr_b_lo_ovf = 0; tmr_b_hi_ovf = 0;
        repeat (40) begin
            if (busy || done_flag) seen++;
            @(negedge clk);
        end
        cnv_pin = 0;
        repeat (4) @(negedge clk);
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state, R3 idle tracking in continuous mode
        chk(busy == 0, "R10 busy", int'(busy), 0);
        chk(done_flag == 0, "R10 flag", int'(done_flag), 0);
        chk(conv_strobe == 0, "R10 strobe", int'(conv_strobe), 0);
        chk(result == 0, "R10 result", int'(result), 0);
        chk(track_en == 1, "R3 idle track", int'(track_en), 1);

        // R6 sleep kills tracking
        sleep = 1; @(negedge clk);
        chk(track_en == 0, "R6 sleep idle", int'(track_en), 0);
        sleep = 0; @(negedge clk);

        // directed conversions
        do_conv(2'd0, 0, 0, 0, 0, "R7 continuous");
        do_conv(2'd0, 0, 3, 0, 0, "R7 continuous div3");
        do_conv(2'd1, 1, 1, 1, 0, "R4 lowpower tmrA wide");
        do_conv(2'd2, 1, 2, 0, 0, "R4 lowpower tmrB narrow");
        do_conv(2'd3, 1, 1, 0, 0, "R5 pin lowpower");
        do_conv(2'd3, 0, 2, 0, 0, "R1 pin continuous");
        do_conv(2'd0, 0, 1, 0, 1, "R8 late trigger");
        clear_flag();
        no_start("R8 no queued conversion");

        // R5 idle track follows synchronised pin level
        trig_sel = 2'd3; lp_mode = 1; sar_div = 8'd0;
        repeat (3) @(negedge clk);
        chk(track_en == 1, "R5 pin low tracks", int'(track_en), 1);
        sleep = 1; @(negedge clk);
        chk(track_en == 0, "R6 sleep pin mode", int'(track_en), 0);
        sleep = 0; lp_mode = 0; trig_sel = 2'd0;

        // R2 wrong-width overflow ignored
        clear_flag();
        trig_sel = 2'd1; tmr_a_wide = 1; tmr_a_lo_ovf = 1;
        no_start("R2 tmrA low ovf in 16-bit");
        trig_sel = 2'd2; tmr_b_wide = 0; tmr_b_hi_ovf = 1;
        no_start("R2 tmrB high ovf in 8-bit");
        // R1 unselected sources ignored
        trig_sel = 2'd0; tmr_a_wide = 0; tmr_a_lo_ovf = 1; tmr_b_lo_ovf = 1;
        no_start("R1 timers while soft selected");
        trig_sel = 2'd1; sw_start = 1;
        no_start("R1 soft while timer A selected");
        trig_sel = 2'd2; tmr_b_wide = 0; tmr_a_lo_ovf = 1; cnv_pin = 1;
        no_start("R1 tmrA and pin while timer B selected");

        // R9 clear and set on the same edge
        begin
            int lat;
            clear_flag();
            trig_sel = 2'd0; lp_mode = 0; sar_div = 8'd1;
            repeat (2) @(negedge clk);
            sw_start = 1;
            @(posedge clk);
            @(negedge clk);
            sw_start = 0;
            lat = 0;
            while (lat < exp_lat(1, 0, 0) - 1) begin
                @(posedge clk); @(negedge clk); lat++;
            end
            flag_clr = 1;
            @(posedge clk); @(negedge clk);
            flag_clr = 0;
            chk(done_flag == 1, "R9 set wins over clear", int'(done_flag), 1);
            clear_flag();
            @(negedge clk);
            chk(done_flag == 0, "R9 clear", int'(done_flag), 0);
        end

        // constrained random conversions
        for (int i = 0; i < 40; i++) begin
            logic [1:0] s;
            bit l;
            s = 2'($urandom % 3);
            l = 1'($urandom % 2);
            do_conv(s, l, int'($urandom % 4), 1'($urandom % 2), 0,
                    l ? "R4 random" : "R7 random");
        end

        finish_run();
    end
endmodule